// File: doc/BRIEF.md
# I2C Channel-Select Target

This block is the digital control core of an eight-way downstream bus selector. It sits on an I2C bus as a target with a 7-bit address. The upper four address bits are fixed at binary 1110, and the lower three come from strap pins. A host writes a one-byte control word to choose which downstream channel is connected. The same word can be read back over the bus. From that word the block drives a vector of channel-enable lines, with at most one line high.

Bus lines are sampled with a free-running system clock through a short synchronizer. START, STOP and SCL edges are detected from the sampled lines. A written selection is first held in a pending register. It is copied to the active register only when a STOP is seen, so that a downstream channel is never connected in the middle of a transfer. When a write carries several data bytes, each byte overwrites the pending value, and the last one wins.

Top module: `i2c_chan_sel`

## Requirements
- R1: While `rst_n` is low, and after it is released, `chan_en` is all zero and `sda_oe` is low. A read before any write returns 0x00.
- R2: The block matches address {1110, strap_a[2], strap_a[1], strap_a[0]}, sent MSB first. The eighth bit is the direction bit (1 = read, 0 = write). On a match the block acknowledges by driving `sda_oe` high for the whole ninth SCL clock.
- R3: In a write, every data byte is acknowledged and stored into the pending register. When several bytes are sent in one transaction, the last byte is the one retained.
- R4: Only bits 3:0 of a written byte are kept. Bit 3 enables a channel, and bits 2:0 give its index. If bit 3 is 1, only `chan_en[index]` is high. If bit 3 is 0, all of `chan_en` is low. Bits 7:4 have no effect.
- R5: `chan_en` changes only on a STOP condition. A write that has not yet reached STOP, or that ends in a repeated START, leaves `chan_en` unchanged until the next STOP.
- R6: A read returns the pending register as {0000, bits 3:0}, MSB first. A new bit is driven after each SCL fall. The same byte is sent again for as long as the host acknowledges.
- R7: After the host answers a read byte with NACK (SDA high on the ninth clock), `sda_oe` stays low until the next START.
- R8: A transaction to any other address gets no acknowledge. It stores nothing and never drives `sda_oe`.
- R9: A repeated START discards any partially received byte and restarts address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| strap_a | input | 3 | Address strap pins; [2] is the most significant |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| chan_en | output | NUM_CH | One-hot-or-zero downstream channel enables |

## Verification
The bench checks that `chan_en` holds its old value right after a data byte is acknowledged, and then moves on the STOP. A design that commits at the acknowledge would connect a channel in the middle of a transfer. Multi-byte writes and the cases where bits 7:4 are set catch designs that keep the first byte or decode the high nibble. A partial byte cut off by a repeated START catches shift registers that are not cleared. A read ended by NACK, with a byte whose MSB is 0, catches a target that goes on driving the next byte and would hold SDA low. Address mismatches in the fixed and strap bits show up as a spurious acknowledge or as a change to the selection.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK,
    ST_SKIP
  } tgt_state_e;

  // Address compare: fixed upper nibble followed by the three strap bits.
  function automatic logic addr_hit(input logic [6:0] rx_addr,
                                    input logic [3:0] fixed_hi,
                                    input logic [2:0] strap);
    return rx_addr == {fixed_hi, strap};
  endfunction

endpackage

// File: rtl/chsel_bus_sampler.sv
module chsel_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_s;
  logic                   scl_q;
  logic                   sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA moving while SCL stays high marks START (falling) or STOP (rising).
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/chsel_target_fsm.sv
module chsel_target_fsm
  import chsel_pkg::*;
#(
  parameter logic [3:0] ADDR_FIXED = 4'b1110,
  parameter int         BYTE_W     = 8,
  parameter int         KEEP_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [2:0]        strap,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              wr_stb,
  output logic [KEEP_W-1:0] wr_keep,
  output logic              sda_oe
);

  localparam int              BIT_W    = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  tgt_state_e        state;
  logic [BIT_W-1:0]  bitcnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] rd_sh;
  logic              rw_q;
  logic              ack_on;
  logic [BYTE_W-1:0] next_byte;
  logic              hit;

  assign next_byte = {shreg, sda_s};
  assign hit       = addr_hit(next_byte[BYTE_W-1:1], ADDR_FIXED, strap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      rd_sh   <= '0;
      rw_q    <= 1'b0;
      ack_on  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_keep <= '0;
      sda_oe  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        ack_on <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        ack_on <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shreg  <= next_byte[BYTE_W-2:0];
              bitcnt <= bitcnt + BIT_W'(1);
              if (bitcnt == LAST_BIT) begin
                if (state == ST_ADDR) begin
                  rw_q  <= sda_s;
                  state <= hit ? ST_AACK : ST_SKIP;
                end else begin
                  wr_stb  <= 1'b1;
                  wr_keep <= next_byte[KEEP_W-1:0];
                  state   <= ST_WACK;
                end
              end
            end
          end
          ST_AACK, ST_WACK: begin
            if (scl_fall) begin
              if (!ack_on) begin
                sda_oe <= 1'b1;
                ack_on <= 1'b1;
              end else begin
                ack_on <= 1'b0;
                bitcnt <= '0;
                if (state == ST_AACK && rw_q) begin
                  state  <= ST_RD;
                  rd_sh  <= rd_byte;
                  sda_oe <= ~rd_byte[BYTE_W-1];
                end else begin
                  state  <= ST_WR;
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + BIT_W'(1);
              if (bitcnt == LAST_BIT) state <= ST_RACK;
            end else if (scl_fall) begin
              rd_sh  <= rd_sh << 1;
              sda_oe <= ~rd_sh[BYTE_W-2];
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              if (!ack_on) begin
                sda_oe <= 1'b0;
              end else begin
                ack_on <= 1'b0;
                bitcnt <= '0;
                state  <= ST_RD;
                rd_sh  <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
              end
            end else if (scl_rise) begin
              if (sda_s) state <= ST_SKIP;
              else       ack_on <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe);  // R8

  AST_NO_DRIVE_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK && scl_rise && sda_s && !start_evt && !stop_evt)
      |=> (!sda_oe && state == ST_SKIP));  // R7

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR && bitcnt == '0));  // R9

endmodule

// File: rtl/chsel_ctrl_regs.sv
module chsel_ctrl_regs #(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = $clog2(NUM_CH),
  parameter int CTRL_W = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CTRL_W-1:0] wr_val,
  input  logic              commit,
  output logic [CTRL_W-1:0] pend,
  output logic [NUM_CH-1:0] chan_en
);

  logic [CTRL_W-1:0] active_q;

  function automatic logic [NUM_CH-1:0] sel_decode(input logic [CTRL_W-1:0] c);
    logic [NUM_CH-1:0] v;
    v = '0;
    if (c[CTRL_W-1]) v[c[SEL_W-1:0]] = 1'b1;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      active_q <= '0;
    end else begin
      if (wr_stb) pend <= wr_val;
      if (commit) active_q <= pend;
    end
  end

  assign chan_en = sel_decode(active_q);

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_en));  // R4

  AST_HOLD_UNTIL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(chan_en));  // R5

  AST_PEND_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(pend));  // R3

endmodule

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel #(
  parameter int         NUM_CH      = 8,
  parameter logic [3:0] ADDR_FIXED  = 4'b1110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        strap_a,
  output logic              sda_oe,
  output logic [NUM_CH-1:0] chan_en
);

  localparam int BYTE_W = 8;
  localparam int SEL_W  = $clog2(NUM_CH);
  localparam int CTRL_W = SEL_W + 1;

  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_evt;
  logic              stop_evt;
  logic              wr_stb;
  logic [CTRL_W-1:0] wr_keep;
  logic [CTRL_W-1:0] pend;
  logic [BYTE_W-1:0] rd_byte;

  chsel_bus_sampler #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  assign rd_byte = {{(BYTE_W-CTRL_W){1'b0}}, pend};

  chsel_target_fsm #(
    .ADDR_FIXED(ADDR_FIXED),
    .BYTE_W    (BYTE_W),
    .KEEP_W    (CTRL_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .strap    (strap_a),
    .rd_byte  (rd_byte),
    .wr_stb   (wr_stb),
    .wr_keep  (wr_keep),
    .sda_oe   (sda_oe)
  );

  chsel_ctrl_regs #(
    .NUM_CH(NUM_CH)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .wr_val (wr_keep),
    .commit (stop_evt),
    .pend   (pend),
    .chan_en(chan_en)
  );

endmodule

// File: tb/test_i2c_chan_sel.sv
`timescale 1ns/1ps
module test_i2c_chan_sel;

  localparam int       Q     = 20;
  localparam bit [2:0] STRAP = 3'b101;
  localparam bit [6:0] MYADR = 7'h75;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       host_sda = 1'b1;
  logic       sda_oe;
  logic [7:0] chan_en;
  logic       sda_line;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = host_sda & ~sda_oe;

  i2c_chan_sel i_i2c_chan_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_in (scl),
    .sda_in (sda_line),
    .strap_a(STRAP),
    .sda_oe (sda_oe),
    .chan_en(chan_en)
  );

  // {addr[6:0], data[7:0], exp_ack, exp_en[7:0], exp_readback[7:0]}
  localparam logic [31:0] VEC [7] = '{
    {7'h75, 8'h08, 1'b1, 8'h01, 8'h08},
    {7'h75, 8'h0D, 1'b1, 8'h20, 8'h0D},
    {7'h75, 8'hF7, 1'b1, 8'h00, 8'h07},
    {7'h75, 8'hFA, 1'b1, 8'h04, 8'h0A},
    {7'h74, 8'h0F, 1'b0, 8'h04, 8'h0A},
    {7'h65, 8'h09, 1'b0, 8'h04, 8'h0A},
    {7'h75, 8'h0F, 1'b1, 8'h80, 8'h0F}
  };

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    host_sda = 1'b1; hold(Q);
    scl = 1'b1;      hold(Q);
    host_sda = 1'b0; hold(Q);
    scl = 1'b0;      hold(Q);
  endtask

  task automatic bus_stop;
    host_sda = 1'b0; hold(Q);
    scl = 1'b1;      hold(Q);
    host_sda = 1'b1; hold(Q);
  endtask

  task automatic send_bit(input logic b);
    host_sda = b; hold(Q);
    scl = 1'b1;   hold(2*Q);
    scl = 1'b0;   hold(Q);
  endtask

  task automatic recv_bit(output logic b);
    host_sda = 1'b1; hold(Q);
    scl = 1'b1;      hold(Q);
    b = sda_line;    hold(Q);
    scl = 1'b0;      hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(~host_ack);
  endtask

  task automatic read_back(output logic [7:0] v);
    logic a;
    bus_start;
    send_byte({MYADR, 1'b1}, a);
    recv_byte(1'b0, v);
    bus_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] rd;
    logic [7:0] rd2;

    hold(5);
    check("R1 chan_en in reset", chan_en, 8'h00);
    check("R1 sda_oe in reset", sda_oe, 1'b0);
    rst_n = 1'b1;
    hold(5);
    read_back(rd);
    check("R1 readback after reset", rd, 8'h00);

    // Vector table: write, STOP, check enables, read back.
    for (int k = 0; k < 7; k++) begin
      bus_start;
      send_byte({VEC[k][31:25], 1'b0}, ack);
      check("R2/R8 address ack", ack, VEC[k][16]);
      if (ack) begin
        send_byte(VEC[k][24:17], ack);
        check("R3 data ack", ack, 1'b1);
      end
      bus_stop;
      check("R4/R5 chan_en after stop", chan_en, VEC[k][15:8]);
      read_back(rd);
      check("R6 readback", rd, VEC[k][7:0]);
    end

    // R3: several bytes in one write, last kept.
    bus_start;
    send_byte({MYADR, 1'b0}, ack);
    send_byte(8'h09, ack);
    send_byte(8'h0B, ack);
    send_byte(8'h0E, ack);
    check("R3 third byte ack", ack, 1'b1);
    check("R5 no change before stop", chan_en, 8'h80);
    bus_stop;
    check("R3 last byte active", chan_en, 8'h40);
    read_back(rd);
    check("R3 last byte readback", rd, 8'h0E);

    // R5/R9: write, repeated START, read pending, then STOP commits.
    bus_start;
    send_byte({MYADR, 1'b0}, ack);
    send_byte(8'h0C, ack);
    bus_start;
    check("R5 held across repeated start", chan_en, 8'h40);
    send_byte({MYADR, 1'b1}, ack);
    check("R2 read address ack", ack, 1'b1);
    recv_byte(1'b1, rd);
    recv_byte(1'b0, rd2);
    check("R6 first read byte", rd, 8'h0C);
    check("R6 repeated read byte", rd2, 8'h0C);
    check("R7 released after nack", sda_oe, 1'b0);
    send_bit(1'b1);
    check("R7 still released", sda_oe, 1'b0);
    check("R5 unchanged before stop", chan_en, 8'h40);
    bus_stop;
    check("R5 commit at stop", chan_en, 8'h10);

    // R9: partial byte cut by repeated START.
    bus_start;
    send_byte({MYADR, 1'b0}, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start;
    send_byte({MYADR, 1'b0}, ack);
    check("R9 address after restart", ack, 1'b1);
    send_byte(8'h08, ack);
    bus_stop;
    check("R9 enables after restart", chan_en, 8'h01);
    read_back(rd);
    check("R9 partial byte discarded", rd, 8'h08);

    // R8: read addressed elsewhere gets no ack and no drive.
    bus_start;
    send_byte({7'h77, 1'b1}, ack);
    check("R8 no ack on foreign read", ack, 1'b0);
    recv_byte(1'b0, rd);
    check("R8 no drive on foreign read", rd, 8'hFF);
    bus_stop;
    check("R8 selection kept", chan_en, 8'h01);

    // R1: reset in the middle of operation.
    bus_start;
    send_byte({MYADR, 1'b0}, ack);
    rst_n = 1'b0;
    hold(3);
    check("R1 chan_en cleared by reset", chan_en, 8'h00);
    check("R1 sda_oe cleared by reset", sda_oe, 1'b0);
    scl = 1'b1; host_sda = 1'b1;
    hold(3);
    rst_n = 1'b1;
    hold(5);
    read_back(rd);
    check("R1 readback after mid reset", rd, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule